// File: doc/BRIEF.md
# Circular-Buffer Pointer Address Generator

This block supplies memory addresses for a signal-processing controller. It keeps two pointer registers and two buffer-length registers. On every access strobe the chosen pointer drives the address output during that cycle and is then stepped for the next access. The step can be a plain +1 or −1, or a +1 or −1 that wraps inside a circular buffer whose length comes from one of the two length registers. That length register is chosen separately for each access.

A circular buffer of length N sits in a block of B words, where B is the smallest power of two that is at least N. The block's base is the pointer with its low log2(B) bits cleared. The buffer occupies the first N words of that block. Software loads pointers and lengths through two write ports. Filter loops then strobe accesses with a mode code, and the pointer wraps without any extra instruction. The block has no state machine: each pointer is a register updated by a fixed-priority choice of write, step or hold.

Top module: `ptr_agu`

## Requirements
- R1: After reset both pointers and both length registers are 0, so the address output reads 0 for either pointer select.
- R2: `addr_o` always shows the pointer chosen by `acc_ptr_sel`. In an access cycle this is the value before the step. The stepped value appears after the next rising clock edge.
- R3: Mode 2'b00 adds one to the pointer. 255 wraps to 0.
- R4: Mode 2'b01 subtracts one from the pointer. 0 wraps to 255.
- R5: Mode 2'b10 is modulo increment. The pointer moves to the block base when its offset within the block is at least N−1. Otherwise it adds one.
- R6: Mode 2'b11 is modulo decrement. The pointer moves to base+N−1 when its offset is 0 or greater than N−1. Otherwise it subtracts one.
- R7: When the selected length is 0 or 1, modes 2'b10 and 2'b11 leave the pointer unchanged.
- R8: `acc_ptr_sel` picks pointer 0 or 1 by its value. `acc_len_sel` picks length 0 or 1 by its value. The pointer that is not selected keeps its value.
- R9: If a pointer write and an access target the same pointer in one cycle, the written value is stored. A write to the other pointer does not stop the access from stepping its own pointer.
- R10: With no access strobe and no pointer write, both pointers hold their values.
- R11: A length write takes effect from the next cycle. An access in the same cycle uses the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Pointer load strobe |
| ptr_wr_sel | input | 1 | Pointer to load |
| ptr_wr_data | input | 8 | Pointer load value |
| len_wr_en | input | 1 | Length load strobe |
| len_wr_sel | input | 1 | Length register to load |
| len_wr_data | input | 8 | Length load value |
| acc_en | input | 1 | Access strobe; steps the selected pointer |
| acc_ptr_sel | input | 1 | Pointer used for the access and shown on `addr_o` |
| acc_len_sel | input | 1 | Length register used by modulo modes |
| acc_mode | input | 2 | Step mode: 00 +1, 01 −1, 10 modulo +1, 11 modulo −1 |
| addr_o | output | 8 | Current address (selected pointer) |

## Verification
The hardest cases to reach are at the edges of the buffer: a pointer at the last in-buffer offset, at offset 0, or beyond N inside a non-power-of-two block. Each of these has to coincide with a chosen length and mode. The stimulus loads pointer and length directly through the write ports before every access. It then sweeps every pointer value against all four modes for lengths 0 to 17 and a set of larger lengths. Every wrap and snap point is therefore reached. The same-cycle write/access and length-update orderings are driven as separate directed sequences.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        MODE_INC     = 2'b00,
        MODE_DEC     = 2'b01,
        MODE_INC_MOD = 2'b10,
        MODE_DEC_MOD = 2'b11
    } step_mode_e;
endpackage

// File: rtl/agu_len_mask.sv
// Turns a buffer length into the offset mask of the enclosing power-of-two block.
module agu_len_mask #(
    parameter int W = 8
) (
    input  logic [W-1:0] len,
    output logic [W-1:0] mask
);
    logic [W-1:0] len_m1;

    always_comb begin
        len_m1 = len - W'(1);
        mask   = len_m1;
        for (int s = 1; s < W; s++) begin
            mask = mask | (len_m1 >> s);
        end
    end
endmodule

// File: rtl/agu_step.sv
// Next-pointer computation for one access.
module agu_step
    import agu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] len,
    input  logic [W-1:0] mask,
    input  step_mode_e   mode,
    output logic [W-1:0] nxt
);
    logic [W-1:0] off;
    logic [W-1:0] base;
    logic [W-1:0] last;
    logic         degenerate;

    assign off        = cur & mask;
    assign base       = cur & ~mask;
    assign last       = len - W'(1);
    assign degenerate = (len[W-1:1] == '0);

    always_comb begin
        nxt = cur;
        unique case (mode)
            MODE_INC: nxt = cur + W'(1);
            MODE_DEC: nxt = cur - W'(1);
            MODE_INC_MOD: begin
                if (degenerate)       nxt = cur;
                else if (off >= last) nxt = base;
                else                  nxt = cur + W'(1);
            end
            MODE_DEC_MOD: begin
                if (degenerate)                     nxt = cur;
                else if (off == '0 || off > last)   nxt = base | last;
                else                                nxt = cur - W'(1);
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import agu_pkg::*;
#(
    parameter int W       = 8,
    parameter int NUM_PTR = 2,
    parameter int NUM_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ptr_wr_en,
    input  logic         ptr_wr_sel,
    input  logic [W-1:0] ptr_wr_data,
    input  logic         len_wr_en,
    input  logic         len_wr_sel,
    input  logic [W-1:0] len_wr_data,
    input  logic         acc_en,
    input  logic         acc_ptr_sel,
    input  logic         acc_len_sel,
    input  logic [1:0]   acc_mode,
    output logic [W-1:0] addr_o
);
    logic [NUM_PTR-1:0][W-1:0] ptr_q;
    logic [NUM_LEN-1:0][W-1:0] len_q;
    logic [W-1:0]              cur_ptr;
    logic [W-1:0]              cur_len;
    logic [W-1:0]              cur_mask;
    logic [W-1:0]              step_nxt;
    step_mode_e                mode;

    assign mode    = step_mode_e'(acc_mode);
    assign cur_ptr = ptr_q[acc_ptr_sel];
    assign cur_len = len_q[acc_len_sel];

    agu_len_mask #(.W(W)) u_mask (
        .len  (cur_len),
        .mask (cur_mask)
    );

    agu_step #(.W(W)) u_step (
        .cur  (cur_ptr),
        .len  (cur_len),
        .mask (cur_mask),
        .mode (mode),
        .nxt  (step_nxt)
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)                                      ptr_q[i] <= '0;
            else if (ptr_wr_en && (ptr_wr_sel == 1'(i)))     ptr_q[i] <= ptr_wr_data;
            else if (acc_en && (acc_ptr_sel == 1'(i)))       ptr_q[i] <= step_nxt;
        end
    end

    for (genvar j = 0; j < NUM_LEN; j++) begin : g_len
        always_ff @(posedge clk) begin
            if (!rst_n)                                      len_q[j] <= '0;
            else if (len_wr_en && (len_wr_sel == 1'(j)))     len_q[j] <= len_wr_data;
        end
    end

    assign addr_o = cur_ptr;
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
#(
    parameter int W       = 8,
    parameter int NUM_PTR = 2,
    parameter int NUM_LEN = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ptr_wr_en,
    input logic                      ptr_wr_sel,
    input logic [W-1:0]              ptr_wr_data,
    input logic                      acc_en,
    input logic                      acc_ptr_sel,
    input logic                      acc_len_sel,
    input logic [1:0]                acc_mode,
    input logic [W-1:0]              addr_o,
    input logic [NUM_PTR-1:0][W-1:0] ptr_q,
    input logic [NUM_LEN-1:0][W-1:0] len_q
);
    logic clash;
    assign clash = ptr_wr_en && (ptr_wr_sel == acc_ptr_sel);

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'b00 && !clash)
        |=> ptr_q[$past(acc_ptr_sel)] == $past(addr_o) + W'(1));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'b01 && !clash)
        |=> ptr_q[$past(acc_ptr_sel)] == $past(addr_o) - W'(1));

    p_degen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode[1] && len_q[acc_len_sel] <= W'(1) && !clash)
        |=> ptr_q[$past(acc_ptr_sel)] == $past(addr_o));

    p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr_en |=> ptr_q[$past(ptr_wr_sel)] == $past(ptr_wr_data));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !ptr_wr_en) |=> $stable(ptr_q));
endmodule

bind ptr_agu agu_chk #(.W(W), .NUM_PTR(NUM_PTR), .NUM_LEN(NUM_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_wr_en   (ptr_wr_en),
    .ptr_wr_sel  (ptr_wr_sel),
    .ptr_wr_data (ptr_wr_data),
    .acc_en      (acc_en),
    .acc_ptr_sel (acc_ptr_sel),
    .acc_len_sel (acc_len_sel),
    .acc_mode    (acc_mode),
    .addr_o      (addr_o),
    .ptr_q       (ptr_q),
    .len_q       (len_q)
);

// File: tb/ptr_agu_tb_top.sv
module ptr_agu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptr_wr_en = 1'b0, ptr_wr_sel = 1'b0;
    logic [7:0] ptr_wr_data = '0;
    logic       len_wr_en = 1'b0, len_wr_sel = 1'b0;
    logic [7:0] len_wr_data = '0;
    logic       acc_en = 1'b0, acc_ptr_sel = 1'b0, acc_len_sel = 1'b0;
    logic [1:0] acc_mode = 2'b00;
    logic [7:0] addr_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [2];

    always #5 clk = ~clk;

    ptr_agu dut_i (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
        .len_wr_en(len_wr_en), .len_wr_sel(len_wr_sel), .len_wr_data(len_wr_data),
        .acc_en(acc_en), .acc_ptr_sel(acc_ptr_sel), .acc_len_sel(acc_len_sel),
        .acc_mode(acc_mode), .addr_o(addr_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input int p, input int n, input logic [1:0] m);
        int b, base, off;
        case (m)
            2'b00: return 8'((p + 1) % 256);
            2'b01: return 8'((p + 255) % 256);
            default: begin
                if (n <= 1) return 8'(p);
                b = 1;
                while (b < n) b = b * 2;
                base = (p / b) * b;
                off  = p - base;
                if (m == 2'b10) return (off >= n - 1) ? 8'(base) : 8'(p + 1);
                return (off == 0 || off > n - 1) ? 8'(base + n - 1) : 8'(p - 1);
            end
        endcase
    endfunction

    task automatic idle();
        ptr_wr_en = 1'b0; len_wr_en = 1'b0; acc_en = 1'b0;
    endtask

    // Load pointer ps=p and length ls=n, access, then read back both pointers.
    task automatic run_case(input logic ps, input logic ls, input int p, input int n,
                            input logic [1:0] m);
        logic [7:0] exp;
        string tag;
        @(negedge clk);
        idle();
        ptr_wr_en = 1'b1; ptr_wr_sel = ps; ptr_wr_data = 8'(p);
        len_wr_en = 1'b1; len_wr_sel = ls; len_wr_data = 8'(n);
        @(negedge clk);
        idle();
        shadow[ps] = 8'(p);
        acc_en = 1'b1; acc_mode = m; acc_ptr_sel = ps; acc_len_sel = ls;
        #2 check("R2 pre-step address", addr_o, 8'(p));
        @(negedge clk);
        idle();
        exp = model(p, n, m);
        if (m[1] && n <= 1) tag = "R7 short length hold";
        else case (m)
            2'b00: tag = "R3 increment";
            2'b01: tag = "R4 decrement";
            2'b10: tag = "R5 modulo increment";
            default: tag = "R6 modulo decrement";
        endcase
        #2 check(tag, addr_o, exp);
        shadow[ps] = exp;
        acc_ptr_sel = ~ps;
        #1 check("R8 other pointer kept", addr_o, shadow[~ps]);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int extras [6] = '{31, 32, 33, 100, 200, 255};
        shadow[0] = 8'd0; shadow[1] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        acc_ptr_sel = 1'b0;
        #2 check("R1 pointer0 reset", addr_o, 8'd0);
        acc_ptr_sel = 1'b1;
        #1 check("R1 pointer1 reset", addr_o, 8'd0);
        @(negedge clk);
        acc_en = 1'b1; acc_mode = 2'b10; acc_ptr_sel = 1'b1; acc_len_sel = 1'b1;
        @(negedge clk);
        idle();
        #2 check("R1 length reset gives hold", addr_o, 8'd0);

        // Sweep all pointers, modes and a set of lengths
        for (int k = 0; k < 24; k++) begin
            int n;
            n = (k < 18) ? k : extras[k - 18];
            for (int p = 0; p < 256; p++) begin
                for (int m = 0; m < 4; m++) begin
                    run_case(1'(p ^ m), 1'(k), p, n, 2'(m));
                end
            end
        end

        // R9: same-pointer write wins over access
        @(negedge clk);
        idle();
        ptr_wr_en = 1'b1; ptr_wr_sel = 1'b0; ptr_wr_data = 8'h40;
        acc_en = 1'b1; acc_ptr_sel = 1'b0; acc_mode = 2'b00;
        @(negedge clk);
        idle(); acc_ptr_sel = 1'b0;
        #2 check("R9 write wins", addr_o, 8'h40);
        // R9: write to other pointer while access steps pointer 0
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_sel = 1'b1; ptr_wr_data = 8'h10;
        acc_en = 1'b1; acc_ptr_sel = 1'b0; acc_mode = 2'b01;
        @(negedge clk);
        idle(); acc_ptr_sel = 1'b0;
        #2 check("R9 access steps own pointer", addr_o, 8'h3F);
        acc_ptr_sel = 1'b1;
        #1 check("R9 other pointer written", addr_o, 8'h10);

        // R10: idle cycles hold both pointers
        repeat (5) @(negedge clk);
        #2 check("R10 pointer1 held", addr_o, 8'h10);
        acc_ptr_sel = 1'b0;
        #1 check("R10 pointer0 held", addr_o, 8'h3F);

        // R11: length write applies next cycle
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_sel = 1'b0; ptr_wr_data = 8'h23;
        len_wr_en = 1'b1; len_wr_sel = 1'b0; len_wr_data = 8'd0;
        @(negedge clk);
        idle();
        len_wr_en = 1'b1; len_wr_sel = 1'b0; len_wr_data = 8'd8;
        acc_en = 1'b1; acc_ptr_sel = 1'b0; acc_len_sel = 1'b0; acc_mode = 2'b10;
        @(negedge clk);
        idle();
        #2 check("R11 old length used", addr_o, 8'h23);
        @(negedge clk);
        acc_en = 1'b1; acc_mode = 2'b10;
        @(negedge clk);
        idle();
        #2 check("R11 new length used", addr_o, 8'h24);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_data = 8'h27;
        @(negedge clk);
        idle(); acc_en = 1'b1; acc_mode = 2'b10;
        @(negedge clk);
        idle();
        #2 check("R11 wrap at new length", addr_o, 8'h20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule